// File: doc/BRIEF.md
# Multi-Polynomial CRC Unit with Bus Snooping

This block computes cyclic redundancy checks over data handed to it on a simple register bus. Software picks one of five standard generator polynomials (8, 16 or 32 bits wide) and a bit order, and can seed or clear the running remainder. It then writes data bytes, halfwords or words to an input register and reads the remainder back. Every byte lane of an access updates the remainder within the same clock. No final XOR or output reflection is applied.

A second input port watches transactions on a peripheral bus. Software enables it and chooses whether reads or writes are watched. When a transaction of the chosen direction hits the programmed 13-bit I/O address, its data byte is folded into the remainder with no software action. The snoop port only observes. It has no ready signal and never stalls the watched bus. The register bus is a plain single-cycle interface. A write takes effect at the clock edge that samples it. Read data is combinational in the same cycle.

Top module: `crc_snoop_unit`

## Requirements
- R1: After reset, every register reads zero: control 0 (offset 0x0), control 1 (0x1), data input (0x4), remainder (0x8) and snoop address (0xC).
- R2: Control 0 keeps the polynomial select in bits 2:0 and the bit order in bit 6. Bits 5:3 and bit 7 always read zero.
- R3: A write to control 0 with bit 7 set zeroes the remainder at that clock edge. A write to control 0 with bit 7 clear leaves the remainder unchanged.
- R4: The polynomial select values map as follows: 001 is CRC-8 (0x07), 010 is CRC-16 (0x8005), 011 is CCITT (0x1021), 100 is CRC-32 (0x04C11DB7) and 101 is CRC-32C (0x1EDC6F41). Remainder bits above the polynomial width read zero after an update.
- R5: With bit order 0, the remainder is computed for LSB-first data, using the reflected polynomial with right shifts, and the bytes of a multi-byte write are taken low byte first. With bit order 1, the remainder is computed for MSB-first data, using the normal polynomial with left shifts, and the bytes are taken high byte first.
- R6: A data-input write folds one byte for size 00, two bytes for size 01 and four bytes for size 10. The new remainder is readable in the next cycle.
- R7: With polynomial select 000, 110 or 111, data-input writes and snoop hits leave the remainder unchanged.
- R8: The remainder register is writable, so software can load a seed. Byte writes replace bits 7:0, halfword writes replace bits 15:0 and word writes replace all 32 bits. Reads of size 00 return bits 7:0 and reads of size 01 return bits 15:0, zero-extended.
- R9: Control 1 bit 7 enables snooping and bit 6 selects the direction: 1 watches writes, 0 watches reads. Bits 5:0 read zero.
- R10: The snoop address register keeps bits 12:0. Bits 15:13 read zero.
- R11: A snoop transaction is folded as one byte only if all three hold: snooping is enabled, its direction matches, and its address equals the programmed one. Any other snoop transaction is ignored.
- R12: A snoop hit in the same cycle as a register-bus write to the data input or the remainder, or as a clear, is dropped. Only the register-bus effect takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | 1 means write, 0 means read |
| bus_addr | input | 4 | Register byte offset |
| bus_size | input | 2 | 00 byte, 01 halfword, 10 or 11 word |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, right-aligned and masked to the access size |
| snp_valid | input | 1 | A transaction is present on the watched bus |
| snp_wr | input | 1 | Direction of that transaction: 1 write, 0 read |
| snp_addr | input | 13 | I/O address of that transaction |
| snp_data | input | 8 | Data byte of that transaction |

## Verification
A corrupted remainder shows up at the next read of offset 0x8, one cycle after the access that caused it. The remainder has no other path to the ports, so a wrong bit persists and spreads through every later update until it is cleared or reseeded. Errors in byte ordering, bit order or polynomial choice show up as a mismatch on the first multi-byte or mode-specific input. Snoop decoding faults appear as a remainder that moves when it should hold, or holds when it should move, at the read that follows the watched transaction.

// File: rtl/crc_snoop_pkg.sv
package crc_snoop_pkg;

  localparam int WORD_W = 32;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    POLY_NONE  = 3'b000,
    POLY_C8    = 3'b001,
    POLY_C16   = 3'b010,
    POLY_CCITT = 3'b011,
    POLY_C32   = 3'b100,
    POLY_C32C  = 3'b101
  } poly_sel_e;

  typedef struct packed {
    word_t      poly;
    logic [5:0] width;
    logic       active;
  } poly_cfg_t;

  function automatic poly_cfg_t decode_poly(logic [2:0] sel);
    poly_cfg_t c;
    c = '{poly: '0, width: 6'd8, active: 1'b0};
    case (sel)
      POLY_C8:    c = '{poly: 32'h0000_0007, width: 6'd8,  active: 1'b1};
      POLY_C16:   c = '{poly: 32'h0000_8005, width: 6'd16, active: 1'b1};
      POLY_CCITT: c = '{poly: 32'h0000_1021, width: 6'd16, active: 1'b1};
      POLY_C32:   c = '{poly: 32'h04C1_1DB7, width: 6'd32, active: 1'b1};
      POLY_C32C:  c = '{poly: 32'h1EDC_6F41, width: 6'd32, active: 1'b1};
      default:    c = '{poly: '0, width: 6'd8, active: 1'b0};
    endcase
    return c;
  endfunction

  function automatic word_t width_mask(logic [5:0] w);
    return (w >= 6'd32) ? '1 : ((word_t'(1) << w) - word_t'(1));
  endfunction

  function automatic word_t reflect_poly(word_t p, logic [5:0] w);
    word_t r;
    r = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (6'(i) < w) r[w - 6'(i) - 6'd1] = p[i];
    end
    return r;
  endfunction

  function automatic word_t merge_sized(word_t old_v, word_t new_v, logic [1:0] size);
    case (size)
      2'b00:   return {old_v[31:8], new_v[7:0]};
      2'b01:   return {old_v[31:16], new_v[15:0]};
      default: return new_v;
    endcase
  endfunction

endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step
  import crc_snoop_pkg::*;
(
  input  word_t      state_i,
  input  logic [7:0] data_i,
  input  word_t      poly_i,
  input  word_t      rpoly_i,
  input  logic [5:0] width_i,
  input  logic       msb_first_i,
  output word_t      state_o
);
  word_t mask;
  word_t c;
  logic  top;

  always_comb begin
    mask = width_mask(width_i);
    c    = state_i & mask;
    top  = 1'b0;
    if (msb_first_i) begin
      c = c ^ (word_t'(data_i) << (width_i - 6'd8));
      for (int b = 0; b < 8; b++) begin
        top = c[width_i - 6'd1];
        c   = (c << 1) & mask;
        if (top) c = c ^ poly_i;
      end
    end else begin
      c = c ^ word_t'(data_i);
      for (int b = 0; b < 8; b++) begin
        top = c[0];
        c   = c >> 1;
        if (top) c = c ^ rpoly_i;
      end
    end
    state_o = c & mask;
  end
endmodule

// File: rtl/crc_fold.sv
module crc_fold
  import crc_snoop_pkg::*;
#(
  parameter int LANES = 4,
  localparam int NB_W = $clog2(LANES) + 1
) (
  input  word_t            state_i,
  input  word_t            data_i,
  input  logic [NB_W-1:0]  nbytes_i,
  input  logic             msb_first_i,
  input  poly_cfg_t        cfg_i,
  output word_t            state_o
);
  word_t chain [LANES+1];
  word_t rpoly;

  assign rpoly    = reflect_poly(cfg_i.poly, cfg_i.width);
  assign chain[0] = state_i;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [NB_W-1:0] lane;
    logic [7:0]      byte_k;
    word_t           nxt_k;

    always_comb begin
      lane   = msb_first_i ? (nbytes_i - NB_W'(k) - NB_W'(1)) : NB_W'(k);
      byte_k = data_i[{lane[NB_W-2:0], 3'b000} +: 8];
    end

    crc_byte_step u_step (
      .state_i     (chain[k]),
      .data_i      (byte_k),
      .poly_i      (cfg_i.poly),
      .rpoly_i     (rpoly),
      .width_i     (cfg_i.width),
      .msb_first_i (msb_first_i),
      .state_o     (nxt_k)
    );

    assign chain[k+1] = (NB_W'(k) < nbytes_i) ? nxt_k : chain[k];
  end

  assign state_o = chain[LANES];
endmodule

// File: rtl/crc_snoop_match.sv
module crc_snoop_match #(
  parameter int AW = 13
) (
  input  logic          enable_i,
  input  logic          watch_wr_i,
  input  logic [AW-1:0] target_i,
  input  logic          valid_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  logic dir_ok;
  logic addr_ok;

  assign dir_ok  = (wr_i == watch_wr_i);
  assign addr_ok = (addr_i == target_i);
  assign hit_o   = enable_i && valid_i && dir_ok && addr_ok;
endmodule

// File: rtl/crc_snoop_unit.sv
module crc_snoop_unit
  import crc_snoop_pkg::*;
#(
  parameter int BUS_AW   = 4,
  parameter int SNOOP_AW = 13,
  parameter int LANES    = 4,
  localparam int NB_W    = $clog2(LANES) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [BUS_AW-1:0]   bus_addr,
  input  logic [1:0]          bus_size,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                snp_valid,
  input  logic                snp_wr,
  input  logic [SNOOP_AW-1:0] snp_addr,
  input  logic [7:0]          snp_data
);
  localparam logic [BUS_AW-1:0] OFF_CTL0 = BUS_AW'(4'h0);
  localparam logic [BUS_AW-1:0] OFF_CTL1 = BUS_AW'(4'h1);
  localparam logic [BUS_AW-1:0] OFF_DIN  = BUS_AW'(4'h4);
  localparam logic [BUS_AW-1:0] OFF_DOUT = BUS_AW'(4'h8);
  localparam logic [BUS_AW-1:0] OFF_SAR  = BUS_AW'(4'hC);

  logic [2:0]          sel_q;
  logic                order_q;
  logic                snp_en_q;
  logic                snp_dir_q;
  logic [SNOOP_AW-1:0] sar_q;
  word_t               din_q;
  word_t               dout_q;

  logic      wr_any;
  logic      ctl0_wr, ctl1_wr, din_wr, dout_wr, sar_wr, clr_req;
  logic      snp_hit, snp_take, fold_en;
  poly_cfg_t cfg;
  logic [NB_W-1:0] bus_nbytes, fold_nbytes;
  word_t     fold_data, fold_out, rd_raw;

  assign wr_any  = bus_sel && bus_wr;
  assign ctl0_wr = wr_any && (bus_addr == OFF_CTL0);
  assign ctl1_wr = wr_any && (bus_addr == OFF_CTL1);
  assign din_wr  = wr_any && (bus_addr == OFF_DIN);
  assign dout_wr = wr_any && (bus_addr == OFF_DOUT);
  assign sar_wr  = wr_any && (bus_addr == OFF_SAR);
  assign clr_req = ctl0_wr && bus_wdata[7];

  assign cfg = decode_poly(sel_q);

  always_comb begin
    case (bus_size)
      2'b00:   bus_nbytes = NB_W'(1);
      2'b01:   bus_nbytes = NB_W'(2);
      default: bus_nbytes = NB_W'(LANES);
    endcase
  end

  crc_snoop_match #(.AW(SNOOP_AW)) u_match (
    .enable_i   (snp_en_q),
    .watch_wr_i (snp_dir_q),
    .target_i   (sar_q),
    .valid_i    (snp_valid),
    .wr_i       (snp_wr),
    .addr_i     (snp_addr),
    .hit_o      (snp_hit)
  );

  assign snp_take    = snp_hit && !din_wr && !dout_wr && !clr_req;
  assign fold_en     = cfg.active && (din_wr || snp_take);
  assign fold_nbytes = din_wr ? bus_nbytes : NB_W'(1);
  assign fold_data   = din_wr ? bus_wdata : word_t'(snp_data);

  crc_fold #(.LANES(LANES)) u_fold (
    .state_i     (dout_q),
    .data_i      (fold_data),
    .nbytes_i    (fold_nbytes),
    .msb_first_i (order_q),
    .cfg_i       (cfg),
    .state_o     (fold_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= '0;
      order_q   <= 1'b0;
      snp_en_q  <= 1'b0;
      snp_dir_q <= 1'b0;
      sar_q     <= '0;
      din_q     <= '0;
    end else begin
      if (ctl0_wr) begin
        sel_q   <= bus_wdata[2:0];
        order_q <= bus_wdata[6];
      end
      if (ctl1_wr) begin
        snp_en_q  <= bus_wdata[7];
        snp_dir_q <= bus_wdata[6];
      end
      if (sar_wr) sar_q <= bus_wdata[SNOOP_AW-1:0];
      if (din_wr) din_q <= merge_sized(din_q, bus_wdata, bus_size);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dout_q <= '0;
    else if (clr_req) dout_q <= '0;
    else if (dout_wr) dout_q <= merge_sized(dout_q, bus_wdata, bus_size);
    else if (fold_en) dout_q <= fold_out;
  end

  always_comb begin
    rd_raw = '0;
    case (bus_addr)
      OFF_CTL0: rd_raw = word_t'({1'b0, order_q, 3'b000, sel_q});
      OFF_CTL1: rd_raw = word_t'({snp_en_q, snp_dir_q, 6'b000000});
      OFF_DIN:  rd_raw = din_q;
      OFF_DOUT: rd_raw = dout_q;
      OFF_SAR:  rd_raw = word_t'(sar_q);
      default:  rd_raw = '0;
    endcase
    if (!bus_sel || bus_wr) bus_rdata = '0;
    else if (bus_size == 2'b00) bus_rdata = rd_raw & 32'h0000_00FF;
    else if (bus_size == 2'b01) bus_rdata = rd_raw & 32'h0000_FFFF;
    else bus_rdata = rd_raw;
  end

  // R3
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (dout_q == '0));

  // R7
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.active && !dout_wr && !clr_req) |=> $stable(dout_q));

  // R11
  snoop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!snp_en_q && !din_wr && !dout_wr && !clr_req) |=> $stable(dout_q));

  // R4
  width_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fold_en && !clr_req && !dout_wr && cfg.width == 6'd8) |=> (dout_q[31:8] == '0));

  // R12
  snoop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && dout_wr && !clr_req && bus_size == 2'b10) |=> (dout_q == $past(bus_wdata)));
endmodule

// File: tb/sim_crc_snoop_unit.sv
module sim_crc_snoop_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        snp_valid = 1'b0, snp_wr = 1'b0;
  logic [12:0] snp_addr = '0;
  logic [7:0]  snp_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];

  logic [31:0] exp_crc;
  logic [2:0]  m_sel;
  logic        m_msb;

  always #2 clk = ~clk;

  crc_snoop_unit u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .snp_valid(snp_valid), .snp_wr(snp_wr),
    .snp_addr(snp_addr), .snp_data(snp_data)
  );

  function automatic logic [31:0] m_step(logic [31:0] c, logic [7:0] d,
                                         logic [2:0] s, logic msb);
    int w;
    logic [31:0] p, rp, mk;
    logic fb;
    case (s)
      3'd1: begin w = 8;  p = 32'h07; end
      3'd2: begin w = 16; p = 32'h8005; end
      3'd3: begin w = 16; p = 32'h1021; end
      3'd4: begin w = 32; p = 32'h04C11DB7; end
      3'd5: begin w = 32; p = 32'h1EDC6F41; end
      default: return c;
    endcase
    mk = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    rp = '0;
    for (int i = 0; i < w; i++) rp[w-1-i] = p[i];
    c = c & mk;
    if (msb) begin
      for (int i = 7; i >= 0; i--) begin
        fb = c[w-1] ^ d[i];
        c  = (c << 1) & mk;
        if (fb) c = c ^ p;
      end
    end else begin
      for (int i = 0; i < 8; i++) begin
        fb = c[0] ^ d[i];
        c  = c >> 1;
        if (fb) c = c ^ rp;
      end
    end
    return c & mk;
  endfunction

  always @(negedge clk) begin
    if (bus_sel && !bus_wr) begin
      item_t it;
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1 unexpected read actual=%h expected=none", bus_rdata);
      end else begin
        it = sb.pop_front();
        checks++;
        if (bus_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [1:0] sz,
                    input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 0; bus_addr = a; bus_size = sz;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic set_mode(input logic [7:0] c0);
    wr(4'h0, 2'b00, {24'h0, c0});
    m_sel = c0[2:0]; m_msb = c0[6];
    if (c0[7]) exp_crc = '0;
  endtask

  task automatic seed(input logic [31:0] v);
    wr(4'h8, 2'b10, v);
    exp_crc = v;
  endtask

  task automatic feed(input logic [7:0] d);
    wr(4'h4, 2'b00, {24'h0, d});
    exp_crc = m_step(exp_crc, d, m_sel, m_msb);
  endtask

  task automatic feed_check_str();
    logic [7:0] s [9];
    s = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    foreach (s[i]) feed(s[i]);
  endtask

  task automatic snoop(input logic w, input logic [12:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    snp_valid = 1; snp_wr = w; snp_addr = a; snp_data = d;
    @(posedge clk); #1;
    snp_valid = 0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_crc = '0; m_sel = '0; m_msb = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset values
    rd(4'h0, 2'b00, 32'h0, "R1 ctl0");
    rd(4'h1, 2'b00, 32'h0, "R1 ctl1");
    rd(4'h4, 2'b10, 32'h0, "R1 din");
    rd(4'h8, 2'b10, 32'h0, "R1 dout");
    rd(4'hC, 2'b01, 32'h0, "R1 sar");

    // R2 control 0 layout, reserved and clear bit read zero
    set_mode(8'hFF);
    rd(4'h0, 2'b00, 32'h47, "R2 ctl0 readback");

    // R4 R5 CRC-8 MSB-first over "123456789"
    set_mode(8'hC1);
    feed_check_str();
    rd(4'h8, 2'b00, 32'hF4, "R4 crc8 check value");
    rd(4'h8, 2'b00, exp_crc, "R5 crc8 model");
    // R3 writing bit7=0 keeps remainder
    set_mode(8'h41);
    rd(4'h8, 2'b00, 32'hF4, "R3 no clear");

    // R5 CRC-16 LSB-first
    set_mode(8'h82);
    feed_check_str();
    rd(4'h8, 2'b01, 32'hBB3D, "R5 crc16 lsb check value");

    // R4 CCITT MSB-first seeded
    set_mode(8'hC3);
    seed(32'h0000FFFF);
    feed_check_str();
    rd(4'h8, 2'b01, 32'h29B1, "R4 ccitt check value");

    // R3 clear
    set_mode(8'hC3);
    rd(4'h8, 2'b10, 32'h0, "R3 clear");

    // R4 CRC-32 LSB-first
    set_mode(8'h84);
    seed(32'hFFFF_FFFF);
    feed_check_str();
    rd(4'h8, 2'b10, 32'h340BC6D9, "R4 crc32 check value");
    // R6 word write, low byte first
    wr(4'h4, 2'b10, 32'h12345678);
    exp_crc = m_step(exp_crc, 8'h78, 3'd4, 1'b0);
    exp_crc = m_step(exp_crc, 8'h56, 3'd4, 1'b0);
    exp_crc = m_step(exp_crc, 8'h34, 3'd4, 1'b0);
    exp_crc = m_step(exp_crc, 8'h12, 3'd4, 1'b0);
    rd(4'h8, 2'b10, exp_crc, "R6 word lsb-first");
    rd(4'h4, 2'b10, 32'h12345678, "R6 din readback");

    // R4 CRC-32C
    set_mode(8'h85);
    seed(32'hFFFF_FFFF);
    feed_check_str();
    rd(4'h8, 2'b10, 32'h1CF96D7C, "R4 crc32c check value");

    // R5 R6 MSB-first word and halfword
    set_mode(8'hC4);
    wr(4'h4, 2'b10, 32'hA1B2C3D4);
    exp_crc = m_step(exp_crc, 8'hA1, 3'd4, 1'b1);
    exp_crc = m_step(exp_crc, 8'hB2, 3'd4, 1'b1);
    exp_crc = m_step(exp_crc, 8'hC3, 3'd4, 1'b1);
    exp_crc = m_step(exp_crc, 8'hD4, 3'd4, 1'b1);
    rd(4'h8, 2'b10, exp_crc, "R5 word msb-first");
    wr(4'h4, 2'b01, 32'h0000BEEF);
    exp_crc = m_step(exp_crc, 8'hBE, 3'd4, 1'b1);
    exp_crc = m_step(exp_crc, 8'hEF, 3'd4, 1'b1);
    rd(4'h8, 2'b10, exp_crc, "R6 halfword msb-first");

    // R8 sized reads and partial seed writes
    rd(4'h8, 2'b00, exp_crc & 32'hFF, "R8 byte read");
    wr(4'h8, 2'b01, 32'hFFFF1234);
    exp_crc = {exp_crc[31:16], 16'h1234};
    rd(4'h8, 2'b10, exp_crc, "R8 halfword seed");

    // R7 no-calculation encodings
    set_mode(8'h40);
    feed(8'h5A);
    wr(4'h4, 2'b10, 32'hDEADBEEF);
    rd(4'h8, 2'b10, exp_crc, "R7 sel 000 holds");
    set_mode(8'h46);
    feed(8'hA5);
    rd(4'h8, 2'b10, exp_crc, "R7 sel 110 holds");

    // R9 R10 snoop config registers
    wr(4'h1, 2'b00, 32'hFF);
    rd(4'h1, 2'b00, 32'hC0, "R9 ctl1 readback");
    wr(4'hC, 2'b01, 32'hFFFF);
    rd(4'hC, 2'b01, 32'h1FFF, "R10 sar readback");

    // R11 snoop on write
    wr(4'hC, 2'b01, 32'h0123);
    set_mode(8'hC1);
    snoop(1'b1, 13'h0123, 8'h31);
    exp_crc = m_step(exp_crc, 8'h31, 3'd1, 1'b1);
    rd(4'h8, 2'b00, exp_crc, "R11 write hit");
    snoop(1'b0, 13'h0123, 8'h77);
    snoop(1'b1, 13'h0125, 8'h77);
    rd(4'h8, 2'b00, exp_crc, "R11 wrong dir or addr ignored");
    // R9 switch to read snooping
    wr(4'h1, 2'b00, 32'h80);
    snoop(1'b0, 13'h0123, 8'h9C);
    exp_crc = m_step(exp_crc, 8'h9C, 3'd1, 1'b1);
    snoop(1'b1, 13'h0123, 8'h11);
    rd(4'h8, 2'b00, exp_crc, "R9 read direction");
    wr(4'h1, 2'b00, 32'h00);
    snoop(1'b0, 13'h0123, 8'h42);
    rd(4'h8, 2'b00, exp_crc, "R11 disabled ignored");

    // R12 collision: direct write wins
    wr(4'h1, 2'b00, 32'hC0);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = 4'h4; bus_size = 2'b00; bus_wdata = 32'h3C;
    snp_valid = 1; snp_wr = 1; snp_addr = 13'h0123; snp_data = 8'hE7;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0; snp_valid = 0;
    exp_crc = m_step(exp_crc, 8'h3C, 3'd1, 1'b1);
    rd(4'h8, 2'b00, exp_crc, "R12 snoop dropped on collision");

    repeat (4) @(posedge clk);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL R1 pending reads actual=%0d expected=0", sb.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule